// File: doc/BRIEF.md
# Scalar Single-Precision Move and Merge Unit

This execution slice performs a one-element single-precision move between a wide vector register and a 32-bit memory word, or between two vector registers. Three encoding families are handled: legacy, VEX and EVEX. Three transfer directions are handled: load, store and register-to-register. The family and the direction decide what happens to the destination bits above the low 32. They are either kept from the old destination, cleared, or copied from the first source. The EVEX family also applies a one-bit writemask to the low element, with either merging or zeroing behaviour.

The issue stage supplies the full old destination register, the bits of the first source that can reach the result, the low word of the second source, and the memory read word. The unit returns a registered destination value, a memory write word, their write enables and an undefined-opcode fault flag. All of these appear one clock after a single-cycle `in_valid` pulse. The move never raises floating-point exceptions and never interprets the data.

Top module: `scalar_move_unit`

## Requirements
- R1: With family code 0 (legacy) and direction code 2 (register), bits 31:0 of the result equal `src2_lo` and bits VLEN-1:32 equal the old destination. `dst_we` is 1.
- R2: With family 0 and direction code 0 (load), bits 31:0 equal `mem_rdata`, bits 127:32 are zero, and bits VLEN-1:128 equal the old destination.
- R3: With family code 1 (VEX) or 2 (EVEX) and direction 2, bits 31:0 come from `src2_lo` (subject to R5), bits 127:32 equal `src1_mid`, and bits VLEN-1:128 are zero.
- R4: With family 1 or 2 and direction 0, bits 31:0 come from `mem_rdata` (subject to R5) and bits VLEN-1:32 are zero.
- R5: For family 2 loads and register moves, the low element is written when `mask_en` is 0 or `mask_bit` is 1. Otherwise the low element keeps the old value when `zero_en` is 0 and becomes zero when `zero_en` is 1. The upper-bit rules of R3 and R4 apply whatever the mask. For families 0 and 1, `mask_bit`, `mask_en` and `zero_en` have no effect.
- R6: For a family 2 store (direction code 1) with `mask_en` 1 and `mask_bit` 0, `mem_we` is 0. A family 2 store with `zero_en` 1 raises `ud_fault`.
- R7: A store in family 1 or 2 with `vvvv` other than 4'b1111 raises `ud_fault`. A legacy store ignores `vvvv`.
- R8: Direction code 3 (memory to memory) and family code 3 (reserved) always raise `ud_fault`.
- R9: Whenever `ud_fault` is 1, both `dst_we` and `mem_we` are 0.
- R10: Outputs are registered. `out_valid` follows `in_valid` by one cycle. When `out_valid` is 0, `dst_we`, `mem_we` and `ud_fault` are 0. A synchronous active-low reset clears every output to zero.
- R11: A store without a fault drives `mem_wdata` equal to `src2_lo` and keeps `dst_we` at 0. A load or register move never raises `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One-cycle operation strobe |
| family | input | 2 | 0 legacy, 1 VEX, 2 EVEX, 3 reserved |
| direction | input | 2 | 0 load, 1 store, 2 register, 3 memory to memory |
| old_dst | input | VLEN | Current destination register contents |
| src1_mid | input | 96 | Bits 127:32 of the first source register |
| src2_lo | input | 32 | Low element of the second source (store data, register move data) |
| mem_rdata | input | 32 | Memory word for loads |
| mask_bit | input | 1 | Writemask bit 0 |
| mask_en | input | 1 | A writemask is applied |
| zero_en | input | 1 | Zeroing masking instead of merging |
| vvvv | input | 4 | Extra register specifier field |
| out_valid | output | 1 | Result strobe |
| dst_data | output | VLEN | New destination value |
| dst_we | output | 1 | Destination write enable |
| mem_wdata | output | 32 | Memory write word |
| mem_we | output | 1 | Memory write enable |
| ud_fault | output | 1 | Undefined-opcode fault |

## Verification
The unit keeps no state between operations apart from the output register, so any error shows up in the result strobe that follows the faulty operation, exactly one cycle after its `in_valid`. A wrong upper-bit rule corrupts a slice of `dst_data` that a given family and direction decide: bits 127:32 or bits above 127. A wrong mask or fault decode shows up as a stray or missing write enable on that same cycle. Random vectors are mixed with directed masking, fault and boundary cases, and `dst_data` and `mem_wdata` are compared only when their enable is expected high.

// File: rtl/smu_pkg.sv
// Shared encodings for the scalar move unit.
// Assumes: family and direction arrive as 2-bit codes from decode.
package smu_pkg;
    typedef enum logic [1:0] {
        FAM_LEGACY = 2'd0,
        FAM_VEX    = 2'd1,
        FAM_EVEX   = 2'd2,
        FAM_RSVD   = 2'd3
    } fam_e;

    typedef enum logic [1:0] {
        DIR_LOAD  = 2'd0,
        DIR_STORE = 2'd1,
        DIR_REG   = 2'd2,
        DIR_M2M   = 2'd3
    } dir_e;

    localparam int ELEM_W  = 32;
    localparam int LANE_W  = 128;
    localparam int MID_W   = LANE_W - ELEM_W;
    localparam logic [3:0] VVVV_IDLE = 4'b1111;
endpackage

// File: rtl/smu_fault_check.sv
// Undefined-opcode detection for the scalar move unit.
// Does: flags reserved codes, memory-to-memory transfers, a non-idle
// register specifier on VEX/EVEX stores, and zeroing on EVEX stores.
// Assumes: purely combinational; the qualification with in_valid is done by the caller.
module smu_fault_check
    import smu_pkg::*;
(
    input  fam_e       fam,
    input  dir_e       dir,
    input  logic [3:0] vvvv,
    input  logic       zero_en,
    output logic       fault
);
    logic bad_code;
    logic bad_vvvv;
    logic bad_zero;

    // Decide each fault cause separately, then combine them.
    always_comb begin
        bad_code = (fam == FAM_RSVD) || (dir == DIR_M2M);
        bad_vvvv = (dir == DIR_STORE) && (fam != FAM_LEGACY) && (vvvv != VVVV_IDLE);
        bad_zero = (dir == DIR_STORE) && (fam == FAM_EVEX) && zero_en;
        fault    = bad_code || bad_vvvv || bad_zero;
    end
endmodule

// File: rtl/smu_dest_merge.sv
// Destination builder for loads and register moves.
// Does: builds the new destination from three regions (low element,
// bits 127:32, bits VLEN-1:128). Each region follows its own rule for the
// encoding family, and EVEX masking applies to the low element.
// Assumes: VLEN >= 128 and a multiple of 32.
module smu_dest_merge
    import smu_pkg::*;
#(
    parameter int VLEN = 512
) (
    input  fam_e              fam,
    input  dir_e              dir,
    input  logic [VLEN-1:0]   old_dst,
    input  logic [MID_W-1:0]  src1_mid,
    input  logic [ELEM_W-1:0] src2_lo,
    input  logic [ELEM_W-1:0] mem_rdata,
    input  logic              mask_bit,
    input  logic              mask_en,
    input  logic              zero_en,
    output logic [VLEN-1:0]   dst_next,
    output logic              dst_req
);
    localparam int TOP_W = VLEN - LANE_W;

    logic              is_load;
    logic              masked_off;
    logic [ELEM_W-1:0] low_cand;
    logic [ELEM_W-1:0] low_val;
    logic [MID_W-1:0]  mid_val;

    // Choose the candidate low element and apply the EVEX writemask to it.
    always_comb begin
        is_load    = (dir == DIR_LOAD);
        low_cand   = is_load ? mem_rdata : src2_lo;
        masked_off = (fam == FAM_EVEX) && mask_en && !mask_bit;
        if (!masked_off)
            low_val = low_cand;
        else if (zero_en)
            low_val = '0;
        else
            low_val = old_dst[ELEM_W-1:0];
    end

    // Bits 127:32: cleared on loads, else kept (legacy) or taken from source 1.
    always_comb begin
        if (is_load)
            mid_val = '0;
        else if (fam == FAM_LEGACY)
            mid_val = old_dst[LANE_W-1:ELEM_W];
        else
            mid_val = src1_mid;
    end

    // Only loads and register moves with a valid family write the destination.
    always_comb begin
        dst_req = ((dir == DIR_LOAD) || (dir == DIR_REG)) && (fam != FAM_RSVD);
    end

    assign dst_next[ELEM_W-1:0]      = low_val;
    assign dst_next[LANE_W-1:ELEM_W] = mid_val;

    generate
        if (TOP_W > 0) begin : g_upper
            logic [TOP_W-1:0] top_val;
            // Bits above 127: kept for legacy forms, cleared for VEX and EVEX.
            always_comb begin
                top_val = (fam == FAM_LEGACY) ? old_dst[VLEN-1:LANE_W] : '0;
            end
            assign dst_next[VLEN-1:LANE_W] = top_val;
        end
    endgenerate
endmodule

// File: rtl/smu_store_path.sv
// Store-side decision for the scalar move unit.
// Does: forwards the low element of source 2 as memory data and decides
// whether the store is requested; a cleared EVEX mask bit suppresses it.
// Assumes: combinational; fault gating happens in the top.
module smu_store_path
    import smu_pkg::*;
(
    input  fam_e              fam,
    input  dir_e              dir,
    input  logic [ELEM_W-1:0] src2_lo,
    input  logic              mask_bit,
    input  logic              mask_en,
    output logic [ELEM_W-1:0] st_data,
    output logic              st_req
);
    // Request a store unless EVEX merging masking blanks the element.
    always_comb begin
        st_data = src2_lo;
        st_req  = (dir == DIR_STORE) && !((fam == FAM_EVEX) && mask_en && !mask_bit);
    end
endmodule

// File: rtl/scalar_move_unit.sv
// Scalar single-precision move/merge execution slice (top).
// Does: combines fault decode, destination merge and store path, and
// registers every output one cycle after in_valid.
// Assumes: one operation per in_valid pulse; synchronous active-low reset.
module scalar_move_unit
    import smu_pkg::*;
#(
    parameter int VLEN = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        family,
    input  logic [1:0]        direction,
    input  logic [VLEN-1:0]   old_dst,
    input  logic [95:0]       src1_mid,
    input  logic [31:0]       src2_lo,
    input  logic [31:0]       mem_rdata,
    input  logic              mask_bit,
    input  logic              mask_en,
    input  logic              zero_en,
    input  logic [3:0]        vvvv,
    output logic              out_valid,
    output logic [VLEN-1:0]   dst_data,
    output logic              dst_we,
    output logic [31:0]       mem_wdata,
    output logic              mem_we,
    output logic              ud_fault
);
    fam_e              fam;
    dir_e              dir;
    logic              fault;
    logic [VLEN-1:0]   dst_next;
    logic              dst_req;
    logic [ELEM_W-1:0] st_data;
    logic              st_req;

    assign fam = fam_e'(family);
    assign dir = dir_e'(direction);

    smu_fault_check u_fault (
        .fam     (fam),
        .dir     (dir),
        .vvvv    (vvvv),
        .zero_en (zero_en),
        .fault   (fault)
    );

    smu_dest_merge #(.VLEN(VLEN)) u_merge (
        .fam       (fam),
        .dir       (dir),
        .old_dst   (old_dst),
        .src1_mid  (src1_mid),
        .src2_lo   (src2_lo),
        .mem_rdata (mem_rdata),
        .mask_bit  (mask_bit),
        .mask_en   (mask_en),
        .zero_en   (zero_en),
        .dst_next  (dst_next),
        .dst_req   (dst_req)
    );

    smu_store_path u_store (
        .fam      (fam),
        .dir      (dir),
        .src2_lo  (src2_lo),
        .mask_bit (mask_bit),
        .mask_en  (mask_en),
        .st_data  (st_data),
        .st_req   (st_req)
    );

    // Register strobes and enables every cycle; a fault blocks both writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dst_we    <= 1'b0;
            mem_we    <= 1'b0;
            ud_fault  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            dst_we    <= in_valid && dst_req && !fault;
            mem_we    <= in_valid && st_req && !fault;
            ud_fault  <= in_valid && fault;
        end
    end

    // Capture data only when an operation is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_data  <= '0;
            mem_wdata <= '0;
        end else if (in_valid) begin
            dst_data  <= dst_next;
            mem_wdata <= st_data;
        end
    end
endmodule

// File: rtl/scalar_move_unit_chk.sv
// Property checker for scalar_move_unit, attached with bind below.
// Does: checks port-level timing, enable gating, fault causes and region rules.
// Assumes: same VLEN as the bound instance.
module scalar_move_unit_chk #(
    parameter int VLEN = 512
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [1:0]      family,
    input logic [1:0]      direction,
    input logic [VLEN-1:0] old_dst,
    input logic [95:0]     src1_mid,
    input logic            mask_bit,
    input logic            mask_en,
    input logic            zero_en,
    input logic [3:0]      vvvv,
    input logic            out_valid,
    input logic [VLEN-1:0] dst_data,
    input logic            dst_we,
    input logic            mem_we,
    input logic            ud_fault
);
    assert_legacy_reg_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && family == 2'd0 && direction == 2'd2)
        |=> (dst_data[VLEN-1:32] == $past(old_dst[VLEN-1:32])));

    assert_legacy_load_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && family == 2'd0 && direction == 2'd0)
        |=> (dst_data[127:32] == '0));

    assert_vex_reg_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (family == 2'd1 || family == 2'd2) && direction == 2'd2)
        |=> (dst_data[127:32] == $past(src1_mid)));

    assert_vex_load_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (family == 2'd1 || family == 2'd2) && direction == 2'd0)
        |=> (dst_data[VLEN-1:32] == '0));

    assert_evex_zeroing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && family == 2'd2 && (direction == 2'd0 || direction == 2'd2)
         && mask_en && !mask_bit && zero_en)
        |=> (dst_data[31:0] == 32'd0));

    assert_store_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && family == 2'd2 && direction == 2'd1 && mask_en && !mask_bit)
        |=> !mem_we);

    assert_vvvv_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (family == 2'd1 || family == 2'd2) && direction == 2'd1 && vvvv != 4'hF)
        |=> ud_fault);

    assert_m2m_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (direction == 2'd3 || family == 2'd3)) |=> ud_fault);

    assert_fault_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ud_fault |-> (!dst_we && !mem_we));

    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!dst_we && !mem_we && !ud_fault));

    assert_store_no_dst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && direction == 2'd1) |=> !dst_we);
endmodule

bind scalar_move_unit scalar_move_unit_chk #(.VLEN(VLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .family    (family),
    .direction (direction),
    .old_dst   (old_dst),
    .src1_mid  (src1_mid),
    .mask_bit  (mask_bit),
    .mask_en   (mask_en),
    .zero_en   (zero_en),
    .vvvv      (vvvv),
    .out_valid (out_valid),
    .dst_data  (dst_data),
    .dst_we    (dst_we),
    .mem_we    (mem_we),
    .ud_fault  (ud_fault)
);

// File: tb/scalar_move_unit_test.sv
module scalar_move_unit_test;
    localparam int VL = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    family = '0;
    logic [1:0]    direction = '0;
    logic [VL-1:0] old_dst = '0;
    logic [95:0]   src1_mid = '0;
    logic [31:0]   src2_lo = '0;
    logic [31:0]   mem_rdata = '0;
    logic          mask_bit = 1'b0;
    logic          mask_en = 1'b0;
    logic          zero_en = 1'b0;
    logic [3:0]    vvvv = 4'hF;
    logic          out_valid;
    logic [VL-1:0] dst_data;
    logic          dst_we;
    logic [31:0]   mem_wdata;
    logic          mem_we;
    logic          ud_fault;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    scalar_move_unit #(.VLEN(VL)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .family(family),
        .direction(direction), .old_dst(old_dst), .src1_mid(src1_mid),
        .src2_lo(src2_lo), .mem_rdata(mem_rdata), .mask_bit(mask_bit),
        .mask_en(mask_en), .zero_en(zero_en), .vvvv(vvvv),
        .out_valid(out_valid), .dst_data(dst_data), .dst_we(dst_we),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .ud_fault(ud_fault)
    );

    function automatic logic [VL-1:0] rnd_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Reference fault rule (R6, R7, R8).
    function automatic logic ref_fault(logic [1:0] f, logic [1:0] d, logic [3:0] vv, logic z);
        if (f == 2'd3 || d == 2'd3) return 1'b1;
        if (d == 2'd1 && f != 2'd0 && vv != 4'hF) return 1'b1;
        if (d == 2'd1 && f == 2'd2 && z) return 1'b1;
        return 1'b0;
    endfunction

    // Reference destination value (R1..R5).
    function automatic logic [VL-1:0] ref_dst(logic [1:0] f, logic [1:0] d, logic [VL-1:0] od,
                                              logic [95:0] s1, logic [31:0] s2, logic [31:0] m,
                                              logic mb, logic me, logic z);
        logic [VL-1:0] r;
        logic [31:0] lo;
        lo = (d == 2'd0) ? m : s2;
        if (f == 2'd2 && me && !mb) lo = z ? 32'd0 : od[31:0];
        if (f == 2'd0) begin
            r = od;
            if (d == 2'd0) r[127:32] = '0;
        end else begin
            r = '0;
            if (d == 2'd2) r[127:32] = s1;
        end
        r[31:0] = lo;
        return r;
    endfunction

    function automatic string tag_of(logic [1:0] f, logic [1:0] d, logic [3:0] vv, logic z,
                                     logic mb, logic me);
        if (f == 2'd3 || d == 2'd3) return "R8";
        if (d == 2'd1 && f == 2'd2 && z) return "R6";
        if (d == 2'd1 && f != 2'd0 && vv != 4'hF) return "R7";
        if (d == 2'd1) return (f == 2'd2 && me && !mb) ? "R6" : "R11";
        if (f == 2'd2 && me && !mb) return "R5";
        if (f == 2'd0) return (d == 2'd2) ? "R1" : "R2";
        return (d == 2'd2) ? "R3" : "R4";
    endfunction

    task automatic check1(string tag, string what, logic [VL-1:0] act, logic [VL-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Issue one operation, then compare the registered outputs one cycle later.
    task automatic apply(logic [1:0] f, logic [1:0] d, logic [VL-1:0] od, logic [95:0] s1,
                         logic [31:0] s2, logic [31:0] m, logic mb, logic me, logic z,
                         logic [3:0] vv);
        logic flt, dwe, mwe;
        logic [VL-1:0] edst;
        string tg;
        @(negedge clk);
        family = f; direction = d; old_dst = od; src1_mid = s1; src2_lo = s2;
        mem_rdata = m; mask_bit = mb; mask_en = me; zero_en = z; vvvv = vv;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        flt  = ref_fault(f, d, vv, z);
        dwe  = !flt && (d == 2'd0 || d == 2'd2);
        mwe  = !flt && d == 2'd1 && !(f == 2'd2 && me && !mb);
        edst = ref_dst(f, d, od, s1, s2, m, mb, me, z);
        tg   = tag_of(f, d, vv, z, mb, me);
        check1(tg, "out_valid R10", VL'(out_valid), VL'(1'b1));
        check1(tg, "ud_fault R9", VL'(ud_fault), VL'(flt));
        check1(tg, "dst_we", VL'(dst_we), VL'(dwe));
        check1(tg, "mem_we", VL'(mem_we), VL'(mwe));
        if (dwe) check1(tg, "dst_data", dst_data, edst);
        if (mwe) check1(tg, "mem_wdata", VL'(mem_wdata), VL'(s2));
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [VL-1:0] od;
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        // R10: reset state
        check1("R10", "reset out_valid", VL'(out_valid), '0);
        check1("R10", "reset dst_data", dst_data, '0);
        check1("R10", "reset enables", VL'({dst_we, mem_we, ud_fault, mem_wdata}), '0);
        rst_n = 1'b1;

        od = rnd_vec();
        // R1: legacy register merge keeps all upper bits
        apply(2'd0, 2'd2, od, 96'h1, 32'hA5A5_0001, 32'h0, 1'b0, 1'b1, 1'b1, 4'h0);
        // R2: legacy load clears 127:32, keeps the rest
        apply(2'd0, 2'd0, od, 96'h2, 32'h0, 32'h3F80_0000, 1'b0, 1'b0, 1'b0, 4'h3);
        // R3: VEX register form copies source 1 and clears above 127
        apply(2'd1, 2'd2, od, {3{32'hDEAD_BEEF}}, 32'h1234_5678, 32'h0, 1'b0, 1'b1, 1'b1, 4'hF);
        // R4: EVEX load, all ones in the old destination
        apply(2'd2, 2'd0, '1, '1, 32'h0, 32'hCAFE_F00D, 1'b1, 1'b1, 1'b0, 4'hF);
        // R5: EVEX merging with mask clear keeps low element
        apply(2'd2, 2'd2, od, {3{32'h5555_AAAA}}, 32'h1111_2222, 32'h0, 1'b0, 1'b1, 1'b0, 4'hF);
        // R5: EVEX zeroing with mask clear, load
        apply(2'd2, 2'd0, '1, '0, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 4'hF);
        // R6: EVEX store with mask clear writes nothing
        apply(2'd2, 2'd1, od, '0, 32'h7777_7777, 32'h0, 1'b0, 1'b1, 1'b0, 4'hF);
        // R6: EVEX store with zeroing faults
        apply(2'd2, 2'd1, od, '0, 32'h7777_7777, 32'h0, 1'b1, 1'b1, 1'b1, 4'hF);
        // R7: VEX store with bad vvvv faults; legacy store ignores vvvv
        apply(2'd1, 2'd1, od, '0, 32'h8888_0000, 32'h0, 1'b0, 1'b0, 1'b0, 4'hE);
        apply(2'd0, 2'd1, od, '0, 32'h8888_0001, 32'h0, 1'b0, 1'b0, 1'b0, 4'h0);
        // R8: memory to memory and reserved family
        apply(2'd0, 2'd3, od, '0, 32'h1, 32'h2, 1'b1, 1'b0, 1'b0, 4'hF);
        apply(2'd3, 2'd2, od, '0, 32'h1, 32'h2, 1'b1, 1'b0, 1'b0, 4'hF);
        // R11: EVEX store, mask set
        apply(2'd2, 2'd1, od, '0, 32'h0BAD_CAFE, 32'h0, 1'b1, 1'b1, 1'b0, 4'hF);
        // R10: idle cycle after an operation drops everything
        @(negedge clk);
        check1("R10", "idle strobe/enables", VL'({out_valid, dst_we, mem_we, ud_fault}), '0);

        for (int k = 0; k < 600; k++) begin
            logic [3:0] vv;
            vv = ($urandom % 4 != 0) ? 4'hF : 4'($urandom);
            apply(2'($urandom), 2'($urandom), rnd_vec(), 96'(rnd_vec()), $urandom, $urandom,
                  1'($urandom), 1'($urandom), ($urandom % 4 == 0), vv);
        end

        // R10: reset mid-stream clears outputs
        @(negedge clk);
        in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check1("R10", "reset after traffic", VL'({out_valid, dst_we, mem_we, ud_fault}), '0);
        check1("R10", "reset data", dst_data, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule